// File: doc/BRIEF.md
# SHA-512 Sigma Unit for a 32-bit Register Pair

This unit executes six scalar hash-support operations for a core whose registers are 32 bits wide. Each operation computes one of the SHA-512 sigma or sum mixing functions on a 64-bit word. The word is split across two source registers. The unit receives the raw 32-bit instruction word and both source register values. It decodes the instruction, joins the two values into one 64-bit operand and applies the selected rotate, shift and XOR network. It returns the lower 32 bits of the mixed word as the destination value.

A strobe on `in_valid` captures the result, a match flag and the destination register index. One cycle later `out_valid` pulses high for that result. The registered outputs keep their values until the next strobe. The unit claims an instruction only when the core runs in 32-bit mode and the hash extension is enabled. Any word it does not claim gives a clear match flag and a zero result, so the surrounding pipeline can raise its own illegal-instruction handling.

Top module: `sha512_pair_sigma_unit`

## Requirements
- R1: The 64-bit operand is {src_hi, src_lo}, with src_lo as bits [31:0]. `out_result` carries bits [31:0] of the mixed 64-bit word.
- R2: Function code 0101000 (big sum 0) yields rotl(x,25) ^ rotl(x,30) ^ rotr(x,28).
- R3: Function code 0101001 (big sum 1) yields rotl(x,23) ^ rotr(x,14) ^ rotr(x,18).
- R4: Function code 0101010 (small sigma 0, low) yields rotr(x,1) ^ rotr(x,7) ^ rotr(x,8).
- R5: Function code 0101011 (small sigma 1, low) yields rotl(x,3) ^ rotr(x,6) ^ rotr(x,19).
- R6: Function code 0101110 (small sigma 0, high) yields rotr(x,1) ^ ({32'b0, x[31:0]} >> 7) ^ rotr(x,8).
- R7: Function code 0101111 (small sigma 1, high) yields rotl(x,3) ^ ({32'b0, x[31:0]} >> 6) ^ rotr(x,19).
- R8: An instruction matches only when bits [6:0] = 0110011, bits [14:12] = 000 and bits [31:25] hold one of the six codes above. Any other word gives `out_match` = 0 and `out_result` = 0.
- R9: When `mode32` or `ext_en` is low, even a correct encoding gives `out_match` = 0 and `out_result` = 0.
- R10: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` is high, and low otherwise.
- R11: While `in_valid` stays low, `out_result`, `out_match` and `out_rd` hold their values.
- R12: Bits [11:7] appear on `out_rd`. Bits [24:15] do not affect the result.
- R13: A synchronous active-high reset clears `out_valid`, `out_result`, `out_match` and `out_rd`. Reset takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that captures the current inputs |
| insn | input | 32 | Instruction word |
| src_lo | input | 32 | First source value, operand bits [31:0] |
| src_hi | input | 32 | Second source value, operand bits [63:32] |
| mode32 | input | 1 | Core runs with 32-bit registers |
| ext_en | input | 1 | Hash extension enabled |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 32 | Lower half of the mixed word, or zero |
| out_match | output | 1 | Instruction claimed by this unit |
| out_rd | output | 5 | Destination register index passed through |

## Verification
The output register can update from a new strobe on the same edge where it presents the previous result. The bench issues back-to-back strobes with different function codes and operands. In each cycle it checks that the value shown belongs to the strobe from one cycle earlier, and that `out_valid` stays high. The bench also raises reset together with a strobe whose encoding is legal. It judges that the reset clear takes priority over the capture, so no valid flag or result leaks through.

// File: rtl/sigpair_pkg.sv
package sigpair_pkg;

  localparam int unsigned HALF_W  = 32;
  localparam int unsigned WORD_W  = 2 * HALF_W;
  localparam int unsigned CODE_W  = 7;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IDX_W   = 5;

  localparam logic [6:0]  MAJOR_OP  = 7'b0110011;
  localparam logic [2:0]  MINOR_OP  = 3'b000;
  localparam logic [CODE_W-1:0] CODE_BSUM0 = 7'b0101000;
  localparam logic [CODE_W-1:0] CODE_BSUM1 = 7'b0101001;
  localparam logic [CODE_W-1:0] CODE_SSIG0L = 7'b0101010;
  localparam logic [CODE_W-1:0] CODE_SSIG1L = 7'b0101011;
  localparam logic [CODE_W-1:0] CODE_SSIG0H = 7'b0101110;
  localparam logic [CODE_W-1:0] CODE_SSIG1H = 7'b0101111;

  typedef enum logic [SEL_W-1:0] {
    MIX_NONE  = 3'd0,
    MIX_BSUM0 = 3'd1,
    MIX_BSUM1 = 3'd2,
    MIX_SSIG0L = 3'd3,
    MIX_SSIG1L = 3'd4,
    MIX_SSIG0H = 3'd5,
    MIX_SSIG1H = 3'd6
  } mix_sel_e;

  function automatic logic [WORD_W-1:0] rot_r(input logic [WORD_W-1:0] v, input int unsigned n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] rot_l(input logic [WORD_W-1:0] v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  // logical right shift of the zero-extended lower half only
  function automatic logic [WORD_W-1:0] lo_shr(input logic [WORD_W-1:0] v, input int unsigned n);
    logic [WORD_W-1:0] z;
    z = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    return z >> n;
  endfunction

  function automatic logic [HALF_W-1:0] mix_low(input mix_sel_e sel, input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    case (sel)
      MIX_BSUM0:  y = rot_l(x, 25) ^ rot_l(x, 30) ^ rot_r(x, 28);
      MIX_BSUM1:  y = rot_l(x, 23) ^ rot_r(x, 14) ^ rot_r(x, 18);
      MIX_SSIG0L: y = rot_r(x, 1)  ^ rot_r(x, 7)  ^ rot_r(x, 8);
      MIX_SSIG1L: y = rot_l(x, 3)  ^ rot_r(x, 6)  ^ rot_r(x, 19);
      MIX_SSIG0H: y = rot_r(x, 1)  ^ lo_shr(x, 7) ^ rot_r(x, 8);
      MIX_SSIG1H: y = rot_l(x, 3)  ^ lo_shr(x, 6) ^ rot_r(x, 19);
      default:    y = '0;
    endcase
    return HALF_W'(y);
  endfunction

endpackage

// File: rtl/sigpair_decode.sv
module sigpair_decode
  import sigpair_pkg::*;
(
  input  logic [HALF_W-1:0] insn,
  input  logic              mode32,
  input  logic              ext_en,
  output mix_sel_e          sel,
  output logic              hit
);

  logic [CODE_W-1:0] code;
  logic              frame_ok;
  logic              unused_idx_bits;
  mix_sel_e          raw_sel;

  assign code            = insn[31:25];
  assign frame_ok        = (insn[6:0] == MAJOR_OP) && (insn[14:12] == MINOR_OP);
  assign unused_idx_bits = ^insn[24:15] ^ ^insn[11:7];

  always_comb begin
    case (code)
      CODE_BSUM0:  raw_sel = MIX_BSUM0;
      CODE_BSUM1:  raw_sel = MIX_BSUM1;
      CODE_SSIG0L: raw_sel = MIX_SSIG0L;
      CODE_SSIG1L: raw_sel = MIX_SSIG1L;
      CODE_SSIG0H: raw_sel = MIX_SSIG0H;
      CODE_SSIG1H: raw_sel = MIX_SSIG1H;
      default:     raw_sel = MIX_NONE;
    endcase
  end

  assign hit = frame_ok && mode32 && ext_en && (raw_sel != MIX_NONE);
  assign sel = hit ? raw_sel : MIX_NONE;

  // R8 / R9: a claimed word always names a real network
  always_comb begin
    assert_hit_has_sel_R8: assert (!hit || sel != MIX_NONE);
    assert_gate_blocks_R9: assert ((mode32 && ext_en) || !hit);
  end

endmodule

// File: rtl/sigpair_mix.sv
module sigpair_mix
  import sigpair_pkg::*;
(
  input  mix_sel_e          sel,
  input  logic [HALF_W-1:0] src_lo,
  input  logic [HALF_W-1:0] src_hi,
  output logic [HALF_W-1:0] low_out
);

  logic [WORD_W-1:0] operand;

  assign operand = {src_hi, src_lo};   // R1: first source is the low half
  assign low_out = mix_low(sel, operand);

  always_comb begin
    assert_none_is_zero_R8: assert (sel != MIX_NONE || low_out == '0);
  end

endmodule

// File: rtl/sha512_pair_sigma_unit.sv
module sha512_pair_sigma_unit
  import sigpair_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] insn,
  input  logic [31:0] src_lo,
  input  logic [31:0] src_hi,
  input  logic        mode32,
  input  logic        ext_en,
  output logic        out_valid,
  output logic [31:0] out_result,
  output logic        out_match,
  output logic [4:0]  out_rd
);

  mix_sel_e          dec_sel;
  logic              dec_hit;
  logic [HALF_W-1:0] mix_low_w;
  logic              accept_ev;

  sigpair_decode u_decode (
    .insn   (insn),
    .mode32 (mode32),
    .ext_en (ext_en),
    .sel    (dec_sel),
    .hit    (dec_hit)
  );

  sigpair_mix u_mix (
    .sel     (dec_sel),
    .src_lo  (src_lo),
    .src_hi  (src_hi),
    .low_out (mix_low_w)
  );

  assign accept_ev = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_match  <= 1'b0;
      out_rd     <= '0;
    end else begin
      out_valid <= accept_ev;
      if (accept_ev) begin
        out_result <= dec_hit ? mix_low_w : '0;
        out_match  <= dec_hit;
        out_rd     <= insn[11:7];
      end
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_match) && $stable(out_rd)));
  assert_unmatched_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !out_match |-> out_result == '0);
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(mode32 && ext_en)) |=> !out_match);
  assert_reset_clears_R13: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_result == '0 && !out_match));

endmodule

// File: tb/tb_sha512_pair_sigma_unit.sv
module tb_sha512_pair_sigma_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] insn;
  logic [31:0] src_lo;
  logic [31:0] src_hi;
  logic        mode32;
  logic        ext_en;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_match;
  logic [4:0]  out_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sha512_pair_sigma_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_lo(src_lo), .src_hi(src_hi), .mode32(mode32), .ext_en(ext_en),
    .out_valid(out_valid), .out_result(out_result),
    .out_match(out_match), .out_rd(out_rd)
  );

  localparam logic [6:0] C0 = 7'b0101000, C1 = 7'b0101001, C2 = 7'b0101010,
                         C3 = 7'b0101011, C4 = 7'b0101110, C5 = 7'b0101111;

  // independent model: rotation by slicing a doubled word
  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [31:0] model(input logic [6:0] code, input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] x, w, lz;
    x  = {hi, lo};
    lz = {32'h0, lo};
    case (code)
      C0: w = rr(x, 64-25) ^ rr(x, 64-30) ^ rr(x, 28);
      C1: w = rr(x, 64-23) ^ rr(x, 14) ^ rr(x, 18);
      C2: w = rr(x, 1) ^ rr(x, 7) ^ rr(x, 8);
      C3: w = rr(x, 64-3) ^ rr(x, 6) ^ rr(x, 19);
      C4: w = rr(x, 1) ^ (lz >> 7) ^ rr(x, 8);
      C5: w = rr(x, 64-3) ^ (lz >> 6) ^ rr(x, 19);
      default: w = 64'h0;
    endcase
    return w[31:0];
  endfunction

  function automatic logic [31:0] enc(input logic [6:0] code, input logic [2:0] f3,
                                     input logic [6:0] opc, input logic [4:0] rd,
                                     input logic [9:0] idx);
    return {code, idx, f3, rd, opc};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [31:0] lo, input logic [31:0] hi,
                       input logic m, input logic e);
    insn = w; src_lo = lo; src_hi = hi; mode32 = m; ext_en = e; in_valid = 1'b1;
  endtask

  // one strobe, then check at the following negedge
  task automatic run_one(input string req, input logic [31:0] w, input logic [31:0] lo,
                         input logic [31:0] hi, input logic m, input logic e,
                         input logic [31:0] exp_res, input logic exp_match);
    @(negedge clk);
    drive(w, lo, hi, m, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({req, " result"}, out_result, exp_res);
    chk({req, " match"}, {31'b0, out_match}, {31'b0, exp_match});
    chk({req, " rd"}, {27'b0, out_rd}, {27'b0, w[11:7]});
  endtask

  task automatic t_reset;
    chk("R13 reset valid", {31'b0, out_valid}, 32'd0);
    chk("R13 reset result", out_result, 32'd0);
    chk("R13 reset match", {31'b0, out_match}, 32'd0);
  endtask

  task automatic t_functions;
    logic [6:0]  codes [6] = '{C0, C1, C2, C3, C4, C5};
    string       tags  [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
    logic [31:0] los [4] = '{32'h89abcdef, 32'hffffffff, 32'h00000001, 32'h0f1e2d3c};
    logic [31:0] his [4] = '{32'h01234567, 32'h00000000, 32'h80000000, 32'hdeadbeef};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 4; j++)
        run_one({tags[i], " R1"}, enc(codes[i], 3'b000, 7'b0110011, 5'(i + j + 1), 10'h155),
                los[j], his[j], 1'b1, 1'b1, model(codes[i], los[j], his[j]), 1'b1);
  endtask

  task automatic t_operand_order;
    // swapping halves must change a low-half sigma (R1)
    run_one("R1 swap", enc(C2, 3'b000, 7'b0110011, 5'd3, 10'h0), 32'h01234567, 32'h89abcdef,
            1'b1, 1'b1, model(C2, 32'h01234567, 32'h89abcdef), 1'b1);
  endtask

  task automatic t_illegal;
    run_one("R8 bad opcode", enc(C0, 3'b000, 7'b0010011, 5'd4, 10'h0), 32'h12345678, 32'h9abcdef0,
            1'b1, 1'b1, 32'h0, 1'b0);
    run_one("R8 bad minor", enc(C1, 3'b001, 7'b0110011, 5'd5, 10'h0), 32'h12345678, 32'h9abcdef0,
            1'b1, 1'b1, 32'h0, 1'b0);
    run_one("R8 bad code", enc(7'b0101100, 3'b000, 7'b0110011, 5'd6, 10'h0), 32'h12345678,
            32'h9abcdef0, 1'b1, 1'b1, 32'h0, 1'b0);
    run_one("R8 bad code hi", enc(7'b1101000, 3'b000, 7'b0110011, 5'd7, 10'h0), 32'h12345678,
            32'h9abcdef0, 1'b1, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_gating;
    run_one("R9 mode off", enc(C3, 3'b000, 7'b0110011, 5'd8, 10'h0), 32'hcafef00d, 32'h5555aaaa,
            1'b0, 1'b1, 32'h0, 1'b0);
    run_one("R9 ext off", enc(C4, 3'b000, 7'b0110011, 5'd9, 10'h0), 32'hcafef00d, 32'h5555aaaa,
            1'b1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_hold;
    logic [31:0] exp;
    exp = model(C5, 32'h13579bdf, 32'h2468ace0);
    run_one("R11 load", enc(C5, 3'b000, 7'b0110011, 5'd17, 10'h0), 32'h13579bdf, 32'h2468ace0,
            1'b1, 1'b1, exp, 1'b1);
    insn = 32'h0; src_lo = 32'hffffffff; src_hi = 32'hffffffff;
    repeat (3) begin
      @(negedge clk);
      chk("R10 idle valid low", {31'b0, out_valid}, 32'd0);
      chk("R11 hold result", out_result, exp);
      chk("R11 hold rd", {27'b0, out_rd}, 32'd17);
    end
  endtask

  task automatic t_index_fields;
    logic [31:0] exp;
    exp = model(C0, 32'h0badf00d, 32'h76543210);
    run_one("R12 idx A", enc(C0, 3'b000, 7'b0110011, 5'd31, 10'h000), 32'h0badf00d, 32'h76543210,
            1'b1, 1'b1, exp, 1'b1);
    run_one("R12 idx B", enc(C0, 3'b000, 7'b0110011, 5'd0, 10'h3ff), 32'h0badf00d, 32'h76543210,
            1'b1, 1'b1, exp, 1'b1);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    drive(enc(C1, 3'b000, 7'b0110011, 5'd10, 10'h0), 32'h11112222, 32'h33334444, 1'b1, 1'b1);
    @(negedge clk);
    chk("R10 b2b first valid", {31'b0, out_valid}, 32'd1);
    chk("R10 b2b first result", out_result, model(C1, 32'h11112222, 32'h33334444));
    drive(enc(C4, 3'b000, 7'b0110011, 5'd11, 10'h0), 32'h55556666, 32'h77778888, 1'b1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 b2b second valid", {31'b0, out_valid}, 32'd1);
    chk("R10 b2b second result", out_result, model(C4, 32'h55556666, 32'h77778888));
    chk("R12 b2b second rd", {27'b0, out_rd}, 32'd11);
    @(negedge clk);
    chk("R10 b2b drop", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_collide;
    @(negedge clk);
    drive(enc(C2, 3'b000, 7'b0110011, 5'd12, 10'h0), 32'hffff0000, 32'h0000ffff, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    chk("R13 collide valid", {31'b0, out_valid}, 32'd0);
    chk("R13 collide result", out_result, 32'd0);
    chk("R13 collide rd", {27'b0, out_rd}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; insn = '0; src_lo = '0; src_hi = '0;
    mode32 = 1'b1; ext_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_functions();
    t_operand_order();
    t_illegal();
    t_gating();
    t_hold();
    t_index_fields();
    t_back_to_back();
    t_reset_collide();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule